// File: doc/BRIEF.md
# Asynchronous Byte-Lane Bus Master

This block runs one transfer at a time on an asynchronous parallel bus with a 24-bit address (16 Mbytes) and a 16-bit data path. A requester presents an address, a direction, a size (byte or word) and write data. The block then drives the address and read/write line, asserts the address strobe together with an upper and/or lower data strobe, and waits for the addressed device to acknowledge or to flag a bus error. It returns a one-cycle response carrying read data or a fault flag, negates the strobes, and accepts the next request once the acknowledge has been withdrawn.

The width of the data path is fixed when reset is applied. With the mode pin high the bus works as 16 lanes: even bytes travel on bits 15..8, odd bytes on bits 7..0, and words use both halves. With the mode pin low only the lower byte lane carries data. The acknowledge and bus-error inputs come from another timing domain and are resynchronized before use. A cycle counter ends a transfer that no device answers.

Top module: `abus_master`

## Requirements
- R1: While reset is asserted and just after it is released, `bus_as_n_o`, `bus_uds_n_o` and `bus_lds_n_o` are high (negated), `bus_rw_o` is high, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: `mode_wide_i` is sampled only while `rst_n` is low (1 = 16-bit, 0 = 8-bit). A change of the pin after reset has no effect on strobe or lane behaviour.
- R3: In 16-bit mode a byte access with address bit 0 = 0 asserts only `bus_uds_n_o` (low) and reads from data bits 15..8; with address bit 0 = 1 it asserts only `bus_lds_n_o` and reads bits 7..0. A read byte is returned in `rsp_rdata_o[7:0]` with bits 15..8 zero.
- R4: In 16-bit mode a word access asserts both data strobes, drives the address with bit 0 forced to 0, and returns all 16 read bits unchanged.
- R5: In 8-bit mode `bus_uds_n_o` stays high, only `bus_lds_n_o` is asserted, the word flag is ignored (every access is a byte at the given address), and read data comes from bits 7..0 only.
- R6: `bus_rw_o` is 1 for a read and 0 for a write. A byte write puts the byte `req_wdata_i[7:0]` on both halves of `bus_wdata_o`; a word write drives `req_wdata_i` unchanged.
- R7: While `bus_as_n_o` is low, `bus_addr_o` and `bus_rw_o` do not change.
- R8: When the synchronized acknowledge is seen, read data is captured and the response is reported with `rsp_err_o` = 0.
- R9: A bus error ends the cycle with `rsp_err_o` = 1 and `rsp_rdata_o` = 0, and takes precedence over an acknowledge seen in the same cycle.
- R10: If neither acknowledge nor bus error arrives, the address strobe stays asserted for exactly 1 + TIMEOUT_CYCLES clocks and the response reports `rsp_err_o` = 1.
- R11: `req_ready_o` is low, and no new cycle starts, while the synchronized acknowledge or bus error is still asserted.
- R12: `rsp_valid_o` is high for exactly one clock per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wide_i | input | 1 | Bus width select sampled during reset: 1 = 16-bit, 0 = 8-bit |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on a clock edge where valid and ready are both high |
| req_addr_i | input | 24 | Byte address |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_wdata_i | input | 16 | Write data (byte in bits 7..0) |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Transfer ended by bus error or timeout |
| rsp_rdata_o | output | 16 | Read data |
| bus_addr_o | output | 24 | Address bus |
| bus_as_n_o | output | 1 | Address strobe, active low |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| bus_uds_n_o | output | 1 | Upper data strobe, active low |
| bus_lds_n_o | output | 1 | Lower data strobe, active low |
| bus_wdata_o | output | 16 | Write data toward the pads |
| bus_wdata_oe_o | output | 1 | Enable for the write-data pad drivers |
| bus_rdata_i | input | 16 | Read data from the pads |
| bus_ack_n_i | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_berr_n_i | input | 1 | Bus error, active low, asynchronous |

## Verification
The awkward situations sit at the edges of the handshake: an acknowledge that lingers after the strobes drop, a bus error that arrives together with an acknowledge, and a device that never answers. The bench plays the device itself, reacting to the strobes with a chosen delay, and can hold the acknowledge low, raise both inputs together, or stay silent so the counter must end the cycle. Lane steering is swept across every combination of width mode, address parity, size and direction, and the mode pin is toggled after reset to show it no longer matters.

// File: rtl/abm_pkg.sv
package abm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_WAIT_ACK,
        ST_RELEASE
    } abm_state_e;

endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/abm_lane.sv
module abm_lane #(
    parameter int DW = 16
) (
    input  logic          wide_i,
    input  logic          word_i,
    input  logic          addr_lsb_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          word_eff_o,
    output logic          uds_n_o,
    output logic          lds_n_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic [DW-1:0] rdata_o
);

    localparam int HALF = DW / 2;

    always_comb begin
        word_eff_o  = wide_i & word_i;
        uds_n_o     = !(wide_i && (word_i || !addr_lsb_i));
        lds_n_o     = !(!wide_i || word_i || addr_lsb_i);
        bus_wdata_o = word_eff_o ? wdata_i : {2{wdata_i[HALF-1:0]}};
        if (word_eff_o)
            rdata_o = bus_rdata_i;
        else if (wide_i && !addr_lsb_i)
            rdata_o = {{HALF{1'b0}}, bus_rdata_i[DW-1:HALF]};
        else
            rdata_o = {{HALF{1'b0}}, bus_rdata_i[HALF-1:0]};
    end

endmodule

// File: rtl/abus_master.sv
module abus_master
    import abm_pkg::*;
#(
    parameter int AW             = 24,
    parameter int DW             = 16,
    parameter int TIMEOUT_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wide_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic [AW-1:0] req_addr_i,
    input  logic          req_read_i,
    input  logic          req_word_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          rsp_valid_o,
    output logic          rsp_err_o,
    output logic [DW-1:0] rsp_rdata_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_as_n_o,
    output logic          bus_rw_o,
    output logic          bus_uds_n_o,
    output logic          bus_lds_n_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic          bus_wdata_oe_o,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_ack_n_i,
    input  logic          bus_berr_n_i
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        abm_state_e    state;
        logic [AW-1:0] addr;
        logic          read;
        logic          word;
        logic [DW-1:0] wdata;
        logic [CW-1:0] cnt;
        logic          rsp_valid;
        logic          rsp_err;
        logic [DW-1:0] rsp_rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state: ST_IDLE, addr: '0, read: 1'b1, word: 1'b0, wdata: '0,
        cnt: '0, rsp_valid: 1'b0, rsp_err: 1'b0, rsp_rdata: '0
    };

    regs_t r_d, r_q;
    logic  mode_q;
    logic  ack_s, berr_s;
    logic  word_eff, lane_uds_n, lane_lds_n;
    logic [DW-1:0] lane_wdata, lane_rdata;
    logic  strobing;

    // Width mode is captured on every edge while reset is held, then frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_wide_i;
    end

    abm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({~bus_berr_n_i, ~bus_ack_n_i}),
        .q_o   ({berr_s, ack_s})
    );

    abm_lane #(.DW(DW)) u_lane (
        .wide_i      (mode_q),
        .word_i      (r_q.word),
        .addr_lsb_i  (r_q.addr[0]),
        .wdata_i     (r_q.wdata),
        .bus_rdata_i (bus_rdata_i),
        .word_eff_o  (word_eff),
        .uds_n_o     (lane_uds_n),
        .lds_n_o     (lane_lds_n),
        .bus_wdata_o (lane_wdata),
        .rdata_o     (lane_rdata)
    );

    assign req_ready_o = (r_q.state == ST_IDLE) && !ack_s && !berr_s;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i && req_ready_o) begin
                    r_d.addr  = req_addr_i;
                    r_d.read  = req_read_i;
                    r_d.word  = req_word_i;
                    r_d.wdata = req_wdata_i;
                    r_d.state = ST_ADDR;
                end
            end
            ST_ADDR:   r_d.state = ST_STROBE;
            ST_STROBE: begin
                r_d.cnt   = '0;
                r_d.state = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (berr_s || (!ack_s && r_q.cnt == CNT_LAST)) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_err   = 1'b1;
                    r_d.rsp_rdata = '0;
                    r_d.state     = ST_RELEASE;
                end else if (ack_s) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_err   = 1'b0;
                    r_d.rsp_rdata = r_q.read ? lane_rdata : '0;
                    r_d.state     = ST_RELEASE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RELEASE: r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign strobing       = (r_q.state == ST_STROBE) || (r_q.state == ST_WAIT_ACK);
    assign bus_as_n_o     = !strobing;
    assign bus_uds_n_o    = !strobing || lane_uds_n;
    assign bus_lds_n_o    = !strobing || lane_lds_n;
    assign bus_rw_o       = (r_q.state == ST_IDLE) ? 1'b1 : r_q.read;
    assign bus_addr_o     = {r_q.addr[AW-1:1], r_q.addr[0] & ~word_eff};
    assign bus_wdata_o    = lane_wdata;
    assign bus_wdata_oe_o = !r_q.read && (r_q.state != ST_IDLE) && (r_q.state != ST_RELEASE);
    assign rsp_valid_o    = r_q.rsp_valid;
    assign rsp_err_o      = r_q.rsp_err;
    assign rsp_rdata_o    = r_q.rsp_rdata;

    // R2: width mode frozen once reset has been released
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    // R3: wide byte access asserts exactly one lane strobe
    p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && mode_q && !r_q.word) |-> ($countones({bus_uds_n_o, bus_lds_n_o}) == 1));

    // R4: wide word access uses both lanes on an even address
    p_word_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && mode_q && r_q.word) |-> (!bus_uds_n_o && !bus_lds_n_o && !bus_addr_o[0]));

    // R5: narrow mode never uses the upper lane
    p_narrow_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && !mode_q) |-> (bus_uds_n_o && !bus_lds_n_o));

    // R7: address and direction hold while the address strobe is asserted
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && !$past(bus_as_n_o)) |-> ($stable(bus_addr_o) && $stable(bus_rw_o)));

    // R10: wait counter never passes the programmed limit
    p_cnt_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(TIMEOUT_CYCLES));

    // R11: a cycle starts only after acknowledge and bus error were seen negated
    p_start_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ADDR && $past(r_q.state) == ST_IDLE) |-> (!$past(ack_s) && !$past(berr_s)));

    // R12: the response strobe is a single-cycle pulse
    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: tb/abus_master_test.sv
`timescale 1ns/1ps
module abus_master_test;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_read = 1'b1;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic [23:0] bus_addr;
    logic        bus_as_n, bus_rw, bus_uds_n, bus_lds_n, bus_oe;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        ack_n = 1'b1;
    logic        berr_n = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    abus_master #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wide_i(mode_wide),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_read_i(req_read), .req_word_i(req_word),
        .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
        .bus_addr_o(bus_addr), .bus_as_n_o(bus_as_n), .bus_rw_o(bus_rw),
        .bus_uds_n_o(bus_uds_n), .bus_lds_n_o(bus_lds_n),
        .bus_wdata_o(bus_wdata), .bus_wdata_oe_o(bus_oe),
        .bus_rdata_i(bus_rdata), .bus_ack_n_i(ack_n), .bus_berr_n_i(berr_n)
    );

    // values recorded by the device model and the requester
    logic        s_uds, s_lds, s_rw;
    logic [23:0] s_addr, s_addr2;
    logic [15:0] s_wd;
    int          s_low;
    logic        g_err;
    logic [15:0] g_rd;
    logic        g_pulse_after;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic wide);
        rst_n = 1'b0;
        mode_wide = wide;
        repeat (4) @(negedge clk);
        chk("R1", {bus_as_n, bus_uds_n, bus_lds_n, bus_rw, rsp_valid}, 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {bus_as_n, bus_uds_n, bus_lds_n, bus_rw, rsp_valid, req_ready}, 6'b111101);
    endtask

    // kind: 0 acknowledge, 1 bus error, 2 silent, 3 both together
    task automatic xfer(input logic [23:0] a, input logic rd, input logic wd,
                        input logic [15:0] wv, input logic [15:0] sv,
                        input int kind, input int dly, input logic wide);
        logic        we;
        logic        e_uds, e_lds;
        logic [23:0] e_addr;
        logic [15:0] e_wd, e_rd;
        string       ltag;
        we     = wide & wd;
        e_uds  = !(wide && (wd || !a[0]));
        e_lds  = !(!wide || wd || a[0]);
        e_addr = we ? {a[23:1], 1'b0} : a;
        e_wd   = we ? wv : {wv[7:0], wv[7:0]};
        e_rd   = we ? sv : ((wide && !a[0]) ? {8'h00, sv[15:8]} : {8'h00, sv[7:0]});
        ltag   = !wide ? "R5" : (wd ? "R4" : "R3");
        fork
            begin
                @(negedge clk);
                req_addr = a; req_read = rd; req_word = wd; req_wdata = wv;
                req_valid = 1'b1;
                while (!req_ready) @(negedge clk);
                @(negedge clk);
                req_valid = 1'b0;
                while (!rsp_valid) @(negedge clk);
                g_err = rsp_err;
                g_rd  = rsp_rdata;
                @(negedge clk);
                g_pulse_after = rsp_valid;
            end
            begin
                @(negedge clk);
                while (bus_as_n) @(negedge clk);
                s_low = 1;
                s_uds = bus_uds_n; s_lds = bus_lds_n; s_rw = bus_rw;
                s_addr = bus_addr; s_wd = bus_wdata;
                s_addr2 = bus_addr;
                if (kind != 2) begin
                    for (int k = 0; k < dly; k++) begin
                        @(negedge clk);
                        s_low++;
                    end
                    bus_rdata = sv;
                    ack_n  = (kind == 1) ? 1'b1 : 1'b0;
                    berr_n = (kind == 1 || kind == 3) ? 1'b0 : 1'b1;
                end
                while (1) begin
                    @(negedge clk);
                    if (bus_as_n) break;
                    s_addr2 = bus_addr;
                    s_low++;
                end
                ack_n = 1'b1; berr_n = 1'b1; bus_rdata = 16'h0000;
            end
        join
        chk(ltag, {s_uds, s_lds}, {e_uds, e_lds});
        chk(ltag, s_addr, e_addr);
        chk("R6", s_rw, rd);
        if (!rd) chk("R6", s_wd, e_wd);
        chk("R7", s_addr2, s_addr);
        chk("R12", g_pulse_after, 1'b0);
        if (kind == 0) begin
            chk("R8", g_err, 1'b0);
            if (rd) chk(wide ? ltag : "R5", g_rd, e_rd);
        end else if (kind == 2) begin
            chk("R10", g_err, 1'b1);
            chk("R10", s_low, 1 + TMO);
        end else begin
            chk("R9", {g_err, g_rd}, {1'b1, 16'h0000});
        end
        while (!req_ready) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        for (int m = 1; m >= 0; m--) begin
            do_reset(m[0]);
            for (int i = 0; i < 32; i++) begin
                logic [23:0] a;
                logic [15:0] w;
                a = (24'hA53C00 ^ (24'(i) * 24'h010203)) & 24'hFFFFFE;
                a[0] = i[0];
                w = 16'h1234 + 16'(i) * 16'h1111;
                xfer(a, i[2], i[1], w, ~w ^ 16'(i * 7), 0, i / 8, m[0]);
            end
        end

        do_reset(1'b1);
        // R2: pin change after reset leaves 16-bit lane rules in force
        mode_wide = 1'b0;
        xfer(24'h001000, 1'b1, 1'b0, 16'h0, 16'hBEEF, 0, 1, 1'b1);
        chk("R2", {s_uds, s_lds}, 2'b01);
        xfer(24'h001002, 1'b1, 1'b1, 16'h0, 16'hCAFE, 0, 0, 1'b1);
        chk("R2", g_rd, 16'hCAFE);

        // R9: bus error alone and together with acknowledge
        xfer(24'h123456, 1'b1, 1'b1, 16'h0, 16'h5A5A, 1, 2, 1'b1);
        xfer(24'h123457, 1'b0, 1'b0, 16'h00C3, 16'h5A5A, 3, 0, 1'b1);
        // R10: silent device, read and write
        xfer(24'hFFFFFF, 1'b0, 1'b0, 16'h0077, 16'h0, 2, 0, 1'b1);
        xfer(24'h000000, 1'b1, 1'b1, 16'h0, 16'h0, 2, 0, 1'b1);

        // R11: a lingering acknowledge holds off new requests
        @(negedge clk);
        ack_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", req_ready, 1'b0);
        req_valid = 1'b1; req_read = 1'b1; req_addr = 24'h000010;
        repeat (6) begin
            @(negedge clk);
            chk("R11", bus_as_n, 1'b1);
        end
        req_valid = 1'b0;
        ack_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", req_ready, 1'b1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule